// File: doc/BRIEF.md
# Gated CPU Clock and Reset Sequencer

This block turns one fast reference clock into the two clocks a small retro computer needs: a memory clock at twice the processor rate, and a processor clock made by letting through only every second memory-clock pulse. The processor clock is therefore not a separate divide. Each of its pulses is one of the memory clock's own pulses, so both clocks rise on the same fast-clock edge. Between two processor cycles the memory sees one extra cycle, and a memory shared by the processor and a video fetcher can serve both.

The block also sequences the processor's reset. A small counter is cleared by the external reset and advances once per processor clock pulse. The processor reset output stays high until the 150th pulse, and the counter stops at 160. The processor therefore receives a good number of clock pulses while its reset is still held, which some processor cores need so that they start in a known state. The external reset is active low and asserts asynchronously. Its release passes through a two-stage synchronizer. The fast-clock cycles per half memory-clock period are a parameter (`HALF_DIV`), so an 8 MHz reference with `HALF_DIV = 2` gives a 2 MHz memory clock and a 1 MHz processor clock.

Top module: `sysclk_rst_gen`

## Requirements
- R1: While `rst_n` is low, `mem_clk` and `cpu_clk` are low and `cpu_rst` is high, and no `cpu_clk` pulse appears however long the reset lasts.
- R2: Pulling `rst_n` low forces `mem_clk` low, `cpu_clk` low and `cpu_rst` high at once, without waiting for a `clk` edge.
- R3: After `rst_n` rises, `mem_clk` first goes high on the (2 + `HALF_DIV`)th rising edge of `clk`. From then on every high phase lasts exactly `HALF_DIV` rising edges of `clk`.
- R4: `cpu_clk` passes the first `mem_clk` pulse after reset and every second pulse after it, and drops the others. After k `cpu_clk` pulses, exactly 2k-1 `mem_clk` pulses have occurred.
- R5: `cpu_clk` is high only while `mem_clk` is high, and every `cpu_clk` transition happens on the same `clk` edge as a `mem_clk` transition.
- R6: The reset counter starts at 0 and advances by one on each `cpu_clk` rising edge. `cpu_rst` falls on the same `clk` edge as the 150th `cpu_clk` rising edge, so each of the first 150 processor edges samples reset high.
- R7: The counter stops at 160 and holds there. Once `cpu_rst` has fallen it stays low for any number of further pulses, including more than 256, until the next external reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | External reset, active low, asserts asynchronously |
| mem_clk | output | 1 | Memory clock, period 2*HALF_DIV clk cycles |
| cpu_clk | output | 1 | Processor clock, alternate memory-clock pulses only |
| cpu_rst | output | 1 | Processor reset, active high |

## Verification
Every output is a register clocked by `clk`, so each result appears at the `clk` edge that causes it. The bench samples on falling edges of `clk` and counts those samples from reset release: the first memory-clock rise is due at sample 2 + `HALF_DIV`, and every later transition falls on a sample index the bench computes from the divider ratio. The bench counts reset release in processor pulses, not in time, and expects `cpu_rst` low at the very sample where the 150th processor rise first shows. The asynchronous reset is checked one nanosecond after `rst_n` falls, before any clock edge can occur.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  // Gate phase: PASS lets the next memory pulse reach the CPU clock.
  typedef enum logic {
    PH_PASS = 1'b0,
    PH_DROP = 1'b1
  } gate_phase_e;
endpackage

// File: rtl/memclk_div.sv
module memclk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic mem_clk,
  output logic rise_tick,
  output logic fall_tick
);
  logic last;
  logic mem_q, mem_d;

  generate
    if (HALF_DIV == 1) begin : g_toggle_every
      assign last = 1'b1;
    end else begin : g_counted
      localparam int DIV_W = $clog2(HALF_DIV);
      localparam logic [DIV_W-1:0] LAST_V = DIV_W'(HALF_DIV - 1);
      logic [DIV_W-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = (cnt_q == LAST_V) ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign last = (cnt_q == LAST_V);
    end
  endgenerate

  always_comb begin
    mem_d     = last ? ~mem_q : mem_q;
    rise_tick = last & ~mem_q;
    fall_tick = last &  mem_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= 1'b0;
    else        mem_q <= mem_d;
  end

  assign mem_clk = mem_q;
endmodule

// File: rtl/cpuclk_gate.sv
module cpuclk_gate
  import sysclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_tick,
  input  logic fall_tick,
  output logic cpu_clk,
  output logic cpu_rise
);
  gate_phase_e ph_q, ph_d;
  logic        cpu_q, cpu_d;

  always_comb begin
    cpu_rise = rise_tick & (ph_q == PH_PASS);
    ph_d     = ph_q;
    if (rise_tick) ph_d = (ph_q == PH_PASS) ? PH_DROP : PH_PASS;
    cpu_d = cpu_q;
    if (cpu_rise)       cpu_d = 1'b1;
    else if (fall_tick) cpu_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_PASS;
      cpu_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cpu_q <= cpu_d;
    end
  end

  assign cpu_clk = cpu_q;
endmodule

// File: rtl/cpurst_seq.sv
module cpurst_seq #(
  parameter int CNT_W      = 8,
  parameter int RELEASE_AT = 150,
  parameter int SAT_AT     = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_rise,
  output logic             cpu_rst,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] REL_V = CNT_W'(RELEASE_AT);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT_AT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             adv;

  always_comb begin
    adv   = cpu_rise & (cnt_q < SAT_V);
    cnt_d = adv ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cpu_rst = (cnt_q < REL_V);
  assign count   = cnt_q;
endmodule

// File: rtl/sysclk_rst_gen.sv
module sysclk_rst_gen #(
  parameter int HALF_DIV   = 2,
  parameter int CNT_W      = 8,
  parameter int RELEASE_AT = 150,
  parameter int SAT_AT     = 160
) (
  input  logic clk,
  input  logic rst_n,
  output logic mem_clk,
  output logic cpu_clk,
  output logic cpu_rst
);
  logic [1:0]       sync_q;
  logic             rst_int_n;
  logic             rise_tick, fall_tick, cpu_rise;
  logic [CNT_W-1:0] rst_count;

  // Asynchronous assertion, synchronous two-stage release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  memclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mem_clk   (mem_clk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  cpuclk_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .cpu_clk   (cpu_clk),
    .cpu_rise  (cpu_rise)
  );

  cpurst_seq #(
    .CNT_W      (CNT_W),
    .RELEASE_AT (RELEASE_AT),
    .SAT_AT     (SAT_AT)
  ) u_rst (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cpu_rise (cpu_rise),
    .cpu_rst  (cpu_rst),
    .count    (rst_count)
  );
endmodule

// File: rtl/sysclk_rst_gen_chk.sv
module sysclk_rst_gen_chk #(
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 8,
  parameter int SAT_AT   = 160
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_clk,
  input logic             cpu_clk,
  input logic             cpu_rst,
  input logic [CNT_W-1:0] rst_count
);
  logic        mem_prev, pass_q;
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_prev <= 1'b0;
      pass_q   <= 1'b1;
      hi_run   <= '0;
    end else begin
      mem_prev <= mem_clk;
      if (mem_clk && !mem_prev) pass_q <= ~pass_q;
      hi_run <= mem_clk ? hi_run + 16'd1 : 16'd0;
    end
  end

  // R5
  cpu_in_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk |-> mem_clk);

  // R4
  alt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_clk && !mem_prev) |-> (cpu_clk == pass_q));

  // R3
  mem_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_clk && mem_prev) |-> (hi_run == 16'(HALF_DIV)));

  // R6
  rst_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst) |-> $rose(cpu_clk));

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_count <= CNT_W'(SAT_AT));

  // R7
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rst |=> !cpu_rst);
endmodule

bind sysclk_rst_gen sysclk_rst_gen_chk #(
  .HALF_DIV (HALF_DIV),
  .CNT_W    (CNT_W),
  .SAT_AT   (SAT_AT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_clk   (mem_clk),
  .cpu_clk   (cpu_clk),
  .cpu_rst   (cpu_rst),
  .rst_count (rst_count)
);

// File: tb/sysclk_rst_gen_bench.sv
module sysclk_rst_gen_bench;
  localparam int HALF = 2;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic mem_clk, cpu_clk, cpu_rst;
  int   n_chk  = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  sysclk_rst_gen #(.HALF_DIV(HALF)) u_sysclk_rst_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_clk (mem_clk),
    .cpu_clk (cpu_clk),
    .cpu_rst (cpu_rst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // R1: held reset, outputs idle
  task automatic t_hold_reset(input int cycles);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (mem_clk || cpu_clk || !cpu_rst) bad++;
    end
    check(bad == 0, "R1 idle during reset", bad, 0);
  endtask

  // R3..R7: release reset and measure until 400 CPU pulses
  task automatic t_power_up();
    int n = 0, first_mem_at = 0, mem_r = 0, cpu_r = 0, fall_at = -1;
    int first_pass = -1, align_err = 0, run = 0, run_err = 0, rst_again = 0;
    logic pm = 1'b0, pc = 1'b0, pr = 1'b1;
    rst_n = 1'b1;
    while (cpu_r < 400) begin
      @(negedge clk);
      n++;
      if (mem_clk && !pm) begin
        mem_r++;
        if (mem_r == 1) begin
          first_mem_at = n;
          first_pass   = int'(cpu_clk);
        end
      end
      if (cpu_clk && !pc) cpu_r++;
      if (cpu_clk && !mem_clk) align_err++;
      if ((cpu_clk != pc) && (mem_clk == pm)) align_err++;
      if (mem_clk) run++;
      else if (pm) begin
        if (run != HALF) run_err++;
        run = 0;
      end
      if (!cpu_rst && pr) fall_at = cpu_r;
      if (cpu_rst && !pr) rst_again++;
      pm = mem_clk; pc = cpu_clk; pr = cpu_rst;
    end
    check(first_mem_at == 2 + HALF, "R3 first mem_clk rise", first_mem_at, 2 + HALF);
    check(run_err == 0, "R3 mem_clk high length", run_err, 0);
    check(first_pass == 1, "R4 first pulse passed", first_pass, 1);
    check(mem_r == 2 * cpu_r - 1, "R4 pulse ratio", mem_r, 2 * cpu_r - 1);
    check(align_err == 0, "R5 cpu/mem alignment", align_err, 0);
    check(fall_at == 150, "R6 release pulse index", fall_at, 150);
    check(rst_again == 0, "R7 no reassert after 400 pulses", rst_again, 0);
    check(cpu_rst == 1'b0, "R7 cpu_rst low at end", int'(cpu_rst), 0);
  endtask

  // R2: asynchronous assertion while a CPU pulse is high
  task automatic t_async_reset();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!cpu_clk && guard < 100);
    check(cpu_clk == 1'b1, "R2 setup cpu pulse seen", int'(cpu_clk), 1);
    #0.5 rst_n = 1'b0;
    #1;
    check(mem_clk == 1'b0, "R2 mem_clk forced low", int'(mem_clk), 0);
    check(cpu_clk == 1'b0, "R2 cpu_clk forced low", int'(cpu_clk), 0);
    check(cpu_rst == 1'b1, "R2 cpu_rst forced high", int'(cpu_rst), 1);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_hold_reset(10);
    t_power_up();
    t_async_reset();
    t_hold_reset(20);
    t_power_up();
    finish_run();
  end
endmodule